// File: doc/BRIEF.md
# Transmit Enable Ramp Sequencer

This block brings up a radio transmitter in three timed stages. When the transmit request goes high, the first enable turns on. This first enable is meant for the radio's transmit-command pin. After a programmable gap the second enable turns on, for the power-amplifier enable pin. After a second programmable gap the third enable turns on. A ready flag goes high together with the third stage, so the data path can see when the ramp is complete.

Each gap is a 4-bit step count. One step is either 20 or 40 clock periods, chosen by a step-select input. With a 20 MHz clock and the short step, one step is 1 µs. Both gap counts and the step select are captured at the moment the request is accepted, so the ramp cannot be disturbed while it is running. Dropping the request turns all enables off at once and returns the sequencer to idle, ready for the next request.

Top module: `tx_ramp_seq`

## Requirements
- R1: After synchronous reset, all three enables and the ready flag are low and the sequencer is idle.
- R2: The first enable goes high after the first rising clock edge at which the request is sampled high while idle.
- R3: With the step select at 0 and a first gap of G, the second enable goes high exactly G*20+1 clock edges after the first enable rises.
- R4: With the step select at 1, each step is 40 clocks, so the second enable goes high G*40+1 edges after the first enable.
- R5: The third enable goes high exactly H*P+1 edges after the second enable rises. Here H is the second gap and P is the step length in clocks (20 or 40).
- R6: A gap of zero makes the next stage go high on the very next clock edge.
- R7: The gap values and the step select are captured when the request is accepted. Changing them during a ramp does not move any stage edge of that ramp.
- R8: When the request goes low, all enables and ready go low in the same cycle, before the next clock edge, and the sequencer returns to idle. A new request then starts again from the first stage.
- R9: The ready flag is high exactly when the third enable is high.
- R10: Stages nest: the second enable is never high without the first, and the third is never high without the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req | input | 1 | Transmit request level |
| gap_first | input | 4 | Steps from first to second enable |
| gap_second | input | 4 | Steps from second to third enable |
| slow_step | input | 1 | Step length select: 0 = 20 clocks, 1 = 40 clocks |
| tx_cmd_en | output | 1 | First stage enable (transmit command) |
| tx_pwr_en | output | 1 | Second stage enable (power-amplifier enable) |
| tx_stage3_en | output | 1 | Third stage enable |
| ramp_ready | output | 1 | Ramp complete, high together with the third stage |

## Verification
The ramp is driven with both gaps at zero, with one gap zero and the other non-zero, with both gaps at their maximum under each step length, and with random gap pairs. Together these separate an off-by-one in the stage edges, a swapped pair of gaps, and a wrong step length. Other ramps change the gap and step inputs in the middle of a run, which exposes configuration that is read live instead of latched. Requests released part-way through, followed at once by a new request, show whether the enables drop in the same cycle and whether the sequencer restarts cleanly from the first stage.

// File: rtl/txr_pkg.sv
package txr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAMP1 = 2'd1,
        ST_RAMP2 = 2'd2,
        ST_FULL  = 2'd3
    } ramp_state_e;

    localparam int unsigned GAP_W = 4;

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic             slow;
    } ramp_cfg_t;

    function automatic int unsigned step_clocks(input int unsigned base, input logic slow);
        return slow ? base * 2 : base;
    endfunction

endpackage

// File: rtl/txr_step_prescaler.sv
module txr_step_prescaler #(
    parameter int unsigned BASE_DIV = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic slow,
    input  logic run,
    output logic step
);
    localparam int unsigned MAX_DIV = txr_pkg::step_clocks(BASE_DIV, 1'b1);
    localparam int unsigned SUB_W   = $clog2(MAX_DIV);
    localparam logic [SUB_W-1:0] LOAD_FAST = SUB_W'(txr_pkg::step_clocks(BASE_DIV, 1'b0) - 1);
    localparam logic [SUB_W-1:0] LOAD_SLOW = SUB_W'(MAX_DIV - 1);

    logic [SUB_W-1:0] sub_q;
    logic             slow_q;

    assign step = run && (sub_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q  <= '0;
            slow_q <= 1'b0;
        end else if (clear) begin
            sub_q  <= slow ? LOAD_SLOW : LOAD_FAST;
            slow_q <= slow;
        end else if (run) begin
            if (sub_q == '0)
                sub_q <= slow_q ? LOAD_SLOW : LOAD_FAST;
            else
                sub_q <= sub_q - 1'b1;
        end
    end

    // R3/R4: a step pulse is followed by a full reload, so no step on the next clock
    a_r4_step_spacing: assert property (@(posedge clk) disable iff (rst)
        (step && !clear) |=> !step);

endmodule

// File: rtl/txr_gap_counter.sv
module txr_gap_counter #(
    parameter int unsigned GAP_W = txr_pkg::GAP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             disarm,
    input  logic [GAP_W-1:0] gap,
    input  logic             step,
    output logic             run,
    output logic             expired
);
    logic [GAP_W-1:0] cnt_q;
    logic             armed_q;

    assign run     = armed_q && (cnt_q != '0);
    assign expired = armed_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (disarm) begin
            armed_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= gap;
            armed_q <= 1'b1;
        end else if (step && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R6: a zero gap expires on the following clock
    a_r6_zero_gap: assert property (@(posedge clk) disable iff (rst)
        (load && !disarm && gap == '0) |=> expired);

    // R3: without a step pulse the remaining count does not move
    a_r3_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
        (run && !step && !load && !disarm) |=> (run && $stable(cnt_q)));

endmodule

// File: rtl/tx_ramp_seq.sv
module tx_ramp_seq #(
    parameter int unsigned BASE_DIV = 20,
    parameter int unsigned GAP_W    = txr_pkg::GAP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_req,
    input  logic [GAP_W-1:0] gap_first,
    input  logic [GAP_W-1:0] gap_second,
    input  logic             slow_step,
    output logic             tx_cmd_en,
    output logic             tx_pwr_en,
    output logic             tx_stage3_en,
    output logic             ramp_ready
);
    import txr_pkg::*;

    ramp_state_e      state_q, state_d;
    ramp_cfg_t        cfg_q;
    logic             start, load, disarm;
    logic             step, run, expired;
    logic [GAP_W-1:0] load_gap;
    logic             load_slow;

    assign start     = (state_q == ST_IDLE) && tx_req;
    assign load      = start || (state_q == ST_RAMP1 && expired && tx_req);
    assign disarm    = !tx_req || (state_q == ST_RAMP2 && expired);
    assign load_gap  = start ? gap_first : cfg_q.gap;
    assign load_slow = start ? slow_step : cfg_q.slow;

    txr_step_prescaler #(.BASE_DIV(BASE_DIV)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .slow  (load_slow),
        .run   (run),
        .step  (step)
    );

    txr_gap_counter #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .disarm  (disarm),
        .gap     (load_gap),
        .step    (step),
        .run     (run),
        .expired (expired)
    );

    always_comb begin
        state_d = state_q;
        if (!tx_req) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_RAMP1;
                ST_RAMP1: if (expired) state_d = ST_RAMP2;
                ST_RAMP2: if (expired) state_d = ST_FULL;
                ST_FULL:  state_d = ST_FULL;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                cfg_q.gap  <= gap_second;
                cfg_q.slow <= slow_step;
            end
        end
    end

    assign tx_cmd_en    = tx_req && (state_q != ST_IDLE);
    assign tx_pwr_en    = tx_req && (state_q == ST_RAMP2 || state_q == ST_FULL);
    assign tx_stage3_en = tx_req && (state_q == ST_FULL);
    assign ramp_ready   = tx_stage3_en;

    // R2: an accepted request leaves idle on the next edge
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        start |=> (state_q == ST_RAMP1));

    // R8: a released request always lands in idle
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        !tx_req |=> (state_q == ST_IDLE));

    // R10: stages nest
    a_r10_nesting: assert property (@(posedge clk) disable iff (rst)
        (tx_pwr_en |-> tx_cmd_en) and (tx_stage3_en |-> tx_pwr_en));

    // R7: latched configuration is stable once the ramp is running
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(cfg_q));

endmodule

// File: tb/sim_tx_ramp_seq.sv
module sim_tx_ramp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_req = 1'b0;
    logic [3:0] gap_first = '0;
    logic [3:0] gap_second = '0;
    logic       slow_step = 1'b0;
    logic       tx_cmd_en, tx_pwr_en, tx_stage3_en, ramp_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_ramp_seq u0 (
        .clk(clk), .rst(rst), .tx_req(tx_req),
        .gap_first(gap_first), .gap_second(gap_second), .slow_step(slow_step),
        .tx_cmd_en(tx_cmd_en), .tx_pwr_en(tx_pwr_en),
        .tx_stage3_en(tx_stage3_en), .ramp_ready(ramp_ready)
    );

    function automatic int step_len(input bit sel);
        return sel ? 2 * BASE : BASE;
    endfunction

    function automatic int edge_t2(input int ga, input bit sel);
        return ga * step_len(sel) + 1;
    endfunction

    function automatic int edge_t3(input int ga, input int gb, input bit sel);
        return edge_t2(ga, sel) + gb * step_len(sel) + 1;
    endfunction

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_all_low(input string req);
        chk(tx_cmd_en, 1'b0, req, "t1 low");
        chk(tx_pwr_en, 1'b0, req, "t2 low");
        chk(tx_stage3_en, 1'b0, req, "t3 low");
        chk(ramp_ready, 1'b0, req, "ready low");
    endtask

    // hold < 0 means run to the end of the ramp plus a few cycles
    task automatic ramp(input int ga, input int gb, input bit sel, input int hold, input bit mutate);
        int    n;
        string r2, r3;
        logic  e2, e3;
        n  = (hold < 0) ? edge_t3(ga, gb, sel) + 4 : hold;
        r2 = mutate ? "R7" : (ga == 0 ? "R6" : (sel ? "R4" : "R3"));
        r3 = mutate ? "R7" : (gb == 0 ? "R6" : "R5");
        @(negedge clk);
        gap_first  = 4'(ga);
        gap_second = 4'(gb);
        slow_step  = sel;
        tx_req     = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            e2 = (k >= edge_t2(ga, sel));
            e3 = (k >= edge_t3(ga, gb, sel));
            chk(tx_cmd_en, 1'b1, "R2", "t1");
            chk(tx_pwr_en, e2, r2, "t2");
            chk(tx_stage3_en, e3, r3, "t3");
            chk(ramp_ready, tx_stage3_en, "R9", "ready vs t3");
            chk((tx_pwr_en & ~tx_cmd_en) | (tx_stage3_en & ~tx_pwr_en), 1'b0, "R10", "nesting");
            if (mutate && k == 2) begin
                gap_first  = ~gap_first;
                gap_second = ~gap_second;
                slow_step  = ~slow_step;
            end
        end
        tx_req = 1'b0;
        #1;
        chk_all_low("R8");
        @(negedge clk);
        chk_all_low("R8");
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h1a2b);
        repeat (3) @(negedge clk);
        chk_all_low("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_all_low("R1");

        ramp(0, 0, 1'b0, -1, 1'b0);
        ramp(0, 0, 1'b1, -1, 1'b0);
        ramp(1, 1, 1'b0, -1, 1'b0);
        ramp(1, 0, 1'b1, -1, 1'b0);
        ramp(0, 2, 1'b1, -1, 1'b0);
        ramp(15, 15, 1'b1, -1, 1'b0);
        ramp(15, 0, 1'b0, -1, 1'b0);
        ramp(3, 7, 1'b0, -1, 1'b1);
        ramp(2, 5, 1'b1, -1, 1'b1);
        // releases part-way, each followed by an immediate restart (R8)
        ramp(4, 4, 1'b0, 10, 1'b0);
        ramp(2, 3, 1'b0, edge_t2(2, 1'b0) + 3, 1'b0);
        ramp(1, 2, 1'b1, edge_t3(1, 2, 1'b1) + 1, 1'b0);
        ramp(0, 0, 1'b0, 1, 1'b0);
        ramp(2, 1, 1'b0, -1, 1'b0);

        for (int i = 0; i < 24; i++) begin
            int  ga, gb, hold;
            bit  sel, mut;
            ga   = $urandom_range(0, 15);
            gb   = $urandom_range(0, 15);
            sel  = 1'($urandom_range(0, 1));
            mut  = 1'($urandom_range(0, 1));
            hold = ($urandom_range(0, 3) == 0) ? $urandom_range(1, edge_t3(ga, gb, sel) + 2) : -1;
            ramp(ga, gb, sel, hold, mut);
        end

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule